// File: doc/BRIEF.md
# Burst DMA Writer with Page-Boundary Pause

This block drains an internal word buffer into system memory through a burst bus master port. Software sets a start address, a block size in 32-bit words, a block count, a preferred burst length and a page-boundary size. The engine then splits the work into bursts. A burst never runs past the end of a block and never crosses a page boundary.

When the running address lands on a page boundary while data is still owed, the engine stops and raises a boundary status bit. It holds until software loads a fresh system address, then carries on from that address. A bus error reported at the end of a burst ends the transfer. The engine returns to idle, locks the buffer against new input data and records the address where the damaged block began, so software can retry from there after a data reset.

Status bits are write-one-to-clear and feed one registered interrupt line. Bit 0 is transfer complete, bit 1 is boundary pause and bit 2 is bus error.

Top module: `dma_bnd_engine`

## Requirements
- R1: When a burst ends with the running address on a multiple of the page size and words are still owed, no further burst is requested. Status bit 1 is set, and the next burst starts at the address given on `cfg_sys_addr` with an `addr_load` pulse. No burst ever crosses a page boundary. A start address that already sits on a boundary does not cause a pause.
- R2: The page size is 4096 << `cfg_bound_sel` bytes (4 KB to 512 KB). Boundaries of smaller pages are not pause points.
- R3: Each burst carries min(`cfg_burst`, words left in the block, words left to the boundary) beats. When the block size is not a multiple of the burst length, each block ends with a shorter burst holding the remainder. A burst request holds its address and length until granted.
- R4: When the block size is an exact multiple of `cfg_burst` and no boundary intervenes, every burst has the same length.
- R5: A response with `bus_err` high returns the engine to idle and drops `buf_in_ready`. It stays low until `data_rst`, and `start` is ignored while it is locked.
- R6: A bus error sets status bit 2 and `irq`. The bit stays set until a 1 is written to `sts_clr[2]`.
- R7: `err_blk_addr` holds the start address of the block whose burst failed. A block that begins right after a boundary pause starts at the reloaded address.
- R8: `data_rst` empties the buffer, clears the lock and returns the engine to idle, so a new transfer can start cleanly. Status bits are untouched.
- R9: Status bit 0 and `irq` are set once the last burst of the last block receives an error-free response.
- R10: Status bits clear only where a 1 is written on `sts_clr`. When a set and a clear hit the same bit in the same cycle, the set wins.
- R11: After `rst`: `sts` = 0, `irq` = 0, `busy` = 0, `bus_req` = 0, and `buf_in_ready` = 1.
- R12: Beats carry buffer words in arrival order at addresses rising by 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_rst | input | 1 | Data reset: flush buffer, unlock, idle |
| buf_in_valid | input | 1 | Buffer input word valid |
| buf_in_data | input | DATA_W | Buffer input word |
| buf_in_ready | output | 1 | Buffer can take a word |
| cfg_sys_addr | input | ADDR_W | System address for start or reload |
| cfg_blk_words | input | BLKW_W | Block size in words |
| cfg_blk_cnt | input | BLKC_W | Number of blocks |
| cfg_burst | input | LEN_W | Preferred burst length in beats |
| cfg_bound_sel | input | SEL_W | Page size select |
| start | input | 1 | Start pulse |
| addr_load | input | 1 | Reload pulse while paused |
| sts_clr | input | 3 | Write-one-to-clear for status |
| bus_req | output | 1 | Burst request |
| bus_addr | output | ADDR_W | Burst byte address |
| bus_beats | output | LEN_W | Burst length in beats |
| bus_gnt | input | 1 | Request accepted |
| bus_wvalid | output | 1 | Write beat valid |
| bus_wdata | output | DATA_W | Write beat data |
| bus_wready | input | 1 | Write beat accepted |
| bus_done | input | 1 | Burst response strobe |
| bus_err | input | 1 | Response carries an error |
| sts | output | 3 | Status: done, boundary, error |
| irq | output | 1 | Interrupt, OR of status |
| busy | output | 1 | Engine not idle |
| err_blk_addr | output | ADDR_W | Start address of the failed block |

## Verification
The assertions assume that the configuration inputs stay fixed while `busy` is high, and that block size and block count are nonzero. They also assume that `bus_done` arrives only after the last beat of a burst, as a single-cycle strobe. The bench changes configuration only while the engine is idle or paused, with `cfg_sys_addr` changed only together with `addr_load`. Its bus model grants each request in the cycle it appears. It raises the response strobe for exactly one cycle after counting the beats it was asked for, and injects errors only on that strobe.

// File: rtl/dma_bnd_pkg.sv
package dma_bnd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC,
    ST_CMD,
    ST_DATA,
    ST_RESP,
    ST_PAUSE
  } eng_state_e;

  localparam int STS_W    = 3;
  localparam int STS_DONE = 0;
  localparam int STS_BND  = 1;
  localparam int STS_ERR  = 2;

endpackage

// File: rtl/dma_bnd_fifo.sv
module dma_bnd_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  fill;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign full  = (fill == CNT_W'(DEPTH));
  assign empty = (fill == '0);

endmodule

// File: rtl/dma_bnd_burst_calc.sv
module dma_bnd_burst_calc #(
  parameter int OFF_W      = 20,
  parameter int LEN_W      = 5,
  parameter int BLKW_W     = 12,
  parameter int SEL_W      = 3,
  parameter int MIN_SHIFT  = 12,
  parameter int BEAT_SHIFT = 2
) (
  input  logic [OFF_W-1:0]  addr_lo,
  input  logic [BLKW_W-1:0] words_left,
  input  logic [LEN_W-1:0]  burst_cfg,
  input  logic [SEL_W-1:0]  bound_sel,
  output logic [LEN_W-1:0]  beats,
  output logic              at_bnd
);
  localparam int CMP_W = ((OFF_W > BLKW_W) ? OFF_W : BLKW_W) + LEN_W;

  logic [OFF_W-1:0] page_bytes;
  logic [OFF_W-1:0] page_off;
  logic [OFF_W-1:0] room_words;
  logic [CMP_W-1:0] pick_a, pick_b, pick_c;

  always_comb begin
    page_bytes = OFF_W'(1) << MIN_SHIFT;
    page_bytes = page_bytes << bound_sel;
    page_off   = addr_lo & (page_bytes - 1'b1);
    room_words = (page_bytes - page_off) >> BEAT_SHIFT;
    at_bnd     = (page_off == '0);

    pick_a = (burst_cfg == '0) ? CMP_W'(1) : CMP_W'(burst_cfg);
    pick_b = (CMP_W'(words_left) < pick_a) ? CMP_W'(words_left) : pick_a;
    pick_c = (CMP_W'(room_words) < pick_b) ? CMP_W'(room_words) : pick_b;
    beats  = LEN_W'(pick_c);
  end

endmodule

// File: rtl/dma_bnd_status.sv
module dma_bnd_status #(
  parameter int STS_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [STS_W-1:0] set,
  input  logic [STS_W-1:0] clr,
  output logic [STS_W-1:0] sts,
  output logic             irq
);
  logic [STS_W-1:0] sts_nxt;

  // a fresh event outranks a clear of the same bit
  assign sts_nxt = (sts & ~clr) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      irq <= 1'b0;
    end else begin
      sts <= sts_nxt;
      irq <= |sts_nxt;
    end
  end

endmodule

// File: rtl/dma_bnd_engine.sv
module dma_bnd_engine
  import dma_bnd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int LEN_W      = 5,
  parameter int BLKW_W     = 12,
  parameter int BLKC_W     = 16,
  parameter int SEL_W      = 3,
  parameter int MIN_SHIFT  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_rst,
  input  logic              buf_in_valid,
  input  logic [DATA_W-1:0] buf_in_data,
  output logic              buf_in_ready,
  input  logic [ADDR_W-1:0] cfg_sys_addr,
  input  logic [BLKW_W-1:0] cfg_blk_words,
  input  logic [BLKC_W-1:0] cfg_blk_cnt,
  input  logic [LEN_W-1:0]  cfg_burst,
  input  logic [SEL_W-1:0]  cfg_bound_sel,
  input  logic              start,
  input  logic              addr_load,
  input  logic [2:0]        sts_clr,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LEN_W-1:0]  bus_beats,
  input  logic              bus_gnt,
  output logic              bus_wvalid,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wready,
  input  logic              bus_done,
  input  logic              bus_err,
  output logic [2:0]        sts,
  output logic              irq,
  output logic              busy,
  output logic [ADDR_W-1:0] err_blk_addr
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
  localparam int OFF_W      = MIN_SHIFT + (1 << SEL_W);

  eng_state_e        state_q;
  logic [ADDR_W-1:0] addr_q, blk_start_q, err_addr_q;
  logic [BLKW_W-1:0] words_left_q, blk_words_q;
  logic [BLKC_W-1:0] blks_left_q;
  logic [LEN_W-1:0]  beats_left_q, cur_len_q;
  logic              lock_q;

  logic              fifo_full, fifo_empty, push, beat_fire;
  logic [LEN_W-1:0]  calc_beats;
  logic              calc_at_bnd;
  logic              resp_ok, resp_bad, blk_end, last_blk, finish;
  logic [STS_W-1:0]  sts_set;

  // buffer
  assign push = buf_in_valid && buf_in_ready;

  dma_bnd_fifo #(
    .DATA_W (DATA_W),
    .DEPTH  (FIFO_DEPTH)
  ) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .flush   (data_rst),
    .wr_en   (push),
    .wr_data (buf_in_data),
    .rd_en   (beat_fire),
    .rd_data (bus_wdata),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  assign buf_in_ready = !fifo_full && !lock_q;

  // burst sizing
  dma_bnd_burst_calc #(
    .OFF_W      (OFF_W),
    .LEN_W      (LEN_W),
    .BLKW_W     (BLKW_W),
    .SEL_W      (SEL_W),
    .MIN_SHIFT  (MIN_SHIFT),
    .BEAT_SHIFT (BEAT_SHIFT)
  ) u_calc (
    .addr_lo    (addr_q[OFF_W-1:0]),
    .words_left (words_left_q),
    .burst_cfg  (cfg_burst),
    .bound_sel  (cfg_bound_sel),
    .beats      (calc_beats),
    .at_bnd     (calc_at_bnd)
  );

  // handshakes
  assign beat_fire = (state_q == ST_DATA) && !fifo_empty && bus_wready;
  assign resp_ok   = (state_q == ST_RESP) && bus_done && !bus_err && !data_rst;
  assign resp_bad  = (state_q == ST_RESP) && bus_done &&  bus_err && !data_rst;
  assign blk_end   = (words_left_q == '0);
  assign last_blk  = (blks_left_q <= BLKC_W'(1));
  assign finish    = blk_end && last_blk;

  // sequencer
  always_ff @(posedge clk) begin
    if (rst || data_rst) begin
      state_q      <= ST_IDLE;
      lock_q       <= 1'b0;
      addr_q       <= '0;
      blk_start_q  <= '0;
      words_left_q <= '0;
      blk_words_q  <= '0;
      blks_left_q  <= '0;
      beats_left_q <= '0;
      cur_len_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start && !lock_q) begin
            addr_q       <= cfg_sys_addr;
            blk_start_q  <= cfg_sys_addr;
            words_left_q <= cfg_blk_words;
            blk_words_q  <= cfg_blk_words;
            blks_left_q  <= cfg_blk_cnt;
            state_q      <= ST_CALC;
          end
        end
        ST_CALC: begin
          cur_len_q    <= calc_beats;
          beats_left_q <= calc_beats;
          state_q      <= ST_CMD;
        end
        ST_CMD: begin
          if (bus_gnt) state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (beat_fire) begin
            addr_q       <= addr_q + ADDR_W'(BEAT_BYTES);
            words_left_q <= words_left_q - 1'b1;
            beats_left_q <= beats_left_q - 1'b1;
            if (beats_left_q == LEN_W'(1)) state_q <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (resp_bad) begin
            lock_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (resp_ok) begin
            if (finish) begin
              state_q <= ST_IDLE;
            end else begin
              if (blk_end) begin
                blks_left_q  <= blks_left_q - 1'b1;
                words_left_q <= blk_words_q;
                blk_start_q  <= addr_q;
              end
              state_q <= calc_at_bnd ? ST_PAUSE : ST_CALC;
            end
          end
        end
        ST_PAUSE: begin
          if (addr_load) begin
            addr_q <= cfg_sys_addr;
            if (words_left_q == blk_words_q) blk_start_q <= cfg_sys_addr;
            state_q <= ST_CALC;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // failed-block address survives a data reset
  always_ff @(posedge clk) begin
    if (rst) err_addr_q <= '0;
    else if (resp_bad) err_addr_q <= blk_start_q;
  end

  // status
  always_comb begin
    sts_set           = '0;
    sts_set[STS_DONE] = resp_ok && finish;
    sts_set[STS_BND]  = resp_ok && !finish && calc_at_bnd;
    sts_set[STS_ERR]  = resp_bad;
  end

  dma_bnd_status #(
    .STS_W (STS_W)
  ) u_status (
    .clk (clk),
    .rst (rst),
    .set (sts_set),
    .clr (sts_clr),
    .sts (sts),
    .irq (irq)
  );

  assign bus_req      = (state_q == ST_CMD);
  assign bus_addr     = addr_q;
  assign bus_beats    = cur_len_q;
  assign bus_wvalid   = (state_q == ST_DATA) && !fifo_empty;
  assign busy         = (state_q != ST_IDLE);
  assign err_blk_addr = err_addr_q;

endmodule

// File: rtl/dma_bnd_engine_chk.sv
module dma_bnd_engine_chk
  import dma_bnd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 5,
  parameter int SEL_W      = 3,
  parameter int MIN_SHIFT  = 12,
  parameter int BEAT_SHIFT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              data_rst,
  input eng_state_e        state,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LEN_W-1:0]  bus_beats,
  input logic [LEN_W-1:0]  cfg_burst,
  input logic [SEL_W-1:0]  cfg_bound_sel,
  input logic              bus_done,
  input logic              bus_err,
  input logic              sts_done,
  input logic              sts_err,
  input logic              clr_err,
  input logic              busy,
  input logic              buf_in_ready
);
  logic [31:0] page_sz, addr32, span;
  logic [LEN_W-1:0] eff_burst;

  always_comb begin
    page_sz   = 32'(1) << (MIN_SHIFT + 32'(cfg_bound_sel));
    addr32    = 32'(bus_addr);
    span      = (addr32 & (page_sz - 32'd1)) + (32'(bus_beats) << BEAT_SHIFT);
    eff_burst = (cfg_burst == '0) ? LEN_W'(1) : cfg_burst;
  end

  AST_BEATS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_beats != '0 && bus_beats <= eff_burst)); // R3

  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (span <= page_sz)); // R1

  AST_PAUSE_ON_PAGE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAUSE) |-> ((addr32 & (page_sz - 32'd1)) == 32'd0)); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst || data_rst)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_beats))); // R3

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (rst || data_rst)
    $rose(sts_err) |-> (!busy && !buf_in_ready)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sts_err && !clr_err) |=> sts_err); // R6

  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (rst || data_rst)
    (state == ST_RESP && bus_done && bus_err) |=> sts_err); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_done) |-> !busy); // R9

endmodule

bind dma_bnd_engine dma_bnd_engine_chk #(
  .ADDR_W     (ADDR_W),
  .LEN_W      (LEN_W),
  .SEL_W      (SEL_W),
  .MIN_SHIFT  (MIN_SHIFT),
  .BEAT_SHIFT (BEAT_SHIFT)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .data_rst      (data_rst),
  .state         (state_q),
  .bus_req       (bus_req),
  .bus_gnt       (bus_gnt),
  .bus_addr      (bus_addr),
  .bus_beats     (bus_beats),
  .cfg_burst     (cfg_burst),
  .cfg_bound_sel (cfg_bound_sel),
  .bus_done      (bus_done),
  .bus_err       (bus_err),
  .sts_done      (sts[0]),
  .sts_err       (sts[2]),
  .clr_err       (sts_clr[2]),
  .busy          (busy),
  .buf_in_ready  (buf_in_ready)
);

// File: tb/dma_bnd_engine_bench.sv
`timescale 1ns/1ps
module dma_bnd_engine_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        data_rst = 1'b0;
  logic        buf_in_valid = 1'b0;
  logic [31:0] buf_in_data = '0;
  logic        buf_in_ready;
  logic [31:0] cfg_sys_addr = '0;
  logic [11:0] cfg_blk_words = '0;
  logic [15:0] cfg_blk_cnt = '0;
  logic [4:0]  cfg_burst = '0;
  logic [2:0]  cfg_bound_sel = '0;
  logic        start = 1'b0;
  logic        addr_load = 1'b0;
  logic [2:0]  task_clr = '0;
  logic [2:0]  race_clr = '0;
  logic [2:0]  sts_clr;
  logic        bus_req;
  logic [31:0] bus_addr;
  logic [4:0]  bus_beats;
  logic        bus_gnt;
  logic        bus_wvalid;
  logic [31:0] bus_wdata;
  logic        bus_wready = 1'b1;
  logic        bus_done = 1'b0;
  logic        bus_err = 1'b0;
  logic [2:0]  sts;
  logic        irq;
  logic        busy;
  logic [31:0] err_blk_addr;

  assign sts_clr = task_clr | race_clr;
  assign bus_gnt = bus_req;

  always #4 clk = ~clk;

  dma_bnd_engine u_dma_bnd_engine (
    .clk (clk), .rst (rst), .data_rst (data_rst),
    .buf_in_valid (buf_in_valid), .buf_in_data (buf_in_data), .buf_in_ready (buf_in_ready),
    .cfg_sys_addr (cfg_sys_addr), .cfg_blk_words (cfg_blk_words), .cfg_blk_cnt (cfg_blk_cnt),
    .cfg_burst (cfg_burst), .cfg_bound_sel (cfg_bound_sel),
    .start (start), .addr_load (addr_load), .sts_clr (sts_clr),
    .bus_req (bus_req), .bus_addr (bus_addr), .bus_beats (bus_beats), .bus_gnt (bus_gnt),
    .bus_wvalid (bus_wvalid), .bus_wdata (bus_wdata), .bus_wready (bus_wready),
    .bus_done (bus_done), .bus_err (bus_err),
    .sts (sts), .irq (irq), .busy (busy), .err_blk_addr (err_blk_addr)
  );

  int n_chk = 0;
  int n_fail = 0;

  // bench-owned controls, changed by tasks at posedge only
  logic prod_en = 1'b0;
  logic resync = 1'b0;
  logic stall_en = 1'b0;
  logic race_en = 1'b0;
  int   err_burst = -1;

  // burst log
  logic [31:0] log_addr [64];
  int          log_len  [64];
  int          bn = 0;
  int          bn_base = 0;
  int          data_err = 0;

  // producer
  logic [31:0] prod_cnt = '0;
  logic        prod_acc = 1'b0;
  always @(negedge clk) begin
    if (resync) begin
      prod_cnt = '0;
      prod_acc = 1'b0;
    end else if (prod_acc) begin
      prod_cnt = prod_cnt + 1;
    end
    buf_in_valid = prod_en;
    buf_in_data  = prod_cnt;
    prod_acc     = prod_en && buf_in_ready;
  end

  // bus responder and monitor
  logic [31:0] exp_word = '0;
  int          cur_beats = 0;
  int          beat_cnt = 0;
  logic        done_pend = 1'b0;
  int          cyc = 0;
  always @(negedge clk) begin
    cyc++;
    bus_done = 1'b0;
    bus_err  = 1'b0;
    race_clr = '0;
    if (resync) exp_word = '0;
    if (rst || data_rst) begin
      done_pend = 1'b0;
      beat_cnt  = 0;
    end else begin
      if (done_pend) begin
        bus_done  = 1'b1;
        bus_err   = ((bn - bn_base - 1) == err_burst);
        if (bus_err && race_en) race_clr = 3'b100;
        done_pend = 1'b0;
      end
      if (bus_req) begin
        if (bn - bn_base < 64) begin
          log_addr[bn - bn_base] = bus_addr;
          log_len[bn - bn_base]  = int'(bus_beats);
        end
        bn++;
        cur_beats = int'(bus_beats);
        beat_cnt  = 0;
      end
      bus_wready = stall_en ? ((cyc % 3) != 0) : 1'b1;
      if (bus_wvalid && bus_wready) begin
        if (bus_wdata !== exp_word) data_err++;
        exp_word = exp_word + 1;
        beat_cnt++;
        if (beat_cnt == cur_beats) done_pend = 1'b1;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    bn_base = bn;
  endtask

  task automatic chk_burst(input string req, input int idx, input logic [31:0] a, input int l);
    chk(req, $sformatf("burst %0d addr", idx), 64'(log_addr[idx]), 64'(a));
    chk(req, $sformatf("burst %0d len", idx), 64'(log_len[idx]), 64'(l));
  endtask

  task automatic kick(input logic [31:0] a, input int words, input int blocks, input int burst, input int sel);
    @(negedge clk);
    cfg_sys_addr  = a;
    cfg_blk_words = 12'(words);
    cfg_blk_cnt   = 16'(blocks);
    cfg_burst     = 5'(burst);
    cfg_bound_sel = 3'(sel);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int lim = 0;
    @(negedge clk);
    while (busy && lim < 3000) begin
      @(negedge clk);
      lim++;
    end
    chk(req, "engine back to idle", 64'(busy), 64'(0));
  endtask

  task automatic clear_sts(input logic [2:0] m);
    @(negedge clk);
    task_clr = m;
    @(negedge clk);
    task_clr = '0;
  endtask

  task automatic t_reset();
    chk("R11", "sts after reset", 64'(sts), 64'(0));
    chk("R11", "irq after reset", 64'(irq), 64'(0));
    chk("R11", "busy after reset", 64'(busy), 64'(0));
    chk("R11", "bus_req after reset", 64'(bus_req), 64'(0));
    chk("R11", "buf_in_ready after reset", 64'(buf_in_ready), 64'(1));
  endtask

  task automatic t_uneven();
    int de = data_err;
    clear_log();
    kick(32'h1000_0100, 10, 2, 4, 0);
    wait_idle("R3");
    chk("R3", "burst count", 64'(bn - bn_base), 64'(6));
    chk_burst("R3", 0, 32'h1000_0100, 4);
    chk_burst("R3", 1, 32'h1000_0110, 4);
    chk_burst("R3", 2, 32'h1000_0120, 2);
    chk_burst("R3", 3, 32'h1000_0128, 4);
    chk_burst("R3", 5, 32'h1000_0148, 2);
    chk("R9", "done bit", 64'(sts), 64'(3'b001));
    chk("R9", "irq on done", 64'(irq), 64'(1));
    chk("R12", "data order", 64'(data_err - de), 64'(0));
    clear_sts(3'b001);
    chk("R10", "done cleared by W1C", 64'(sts), 64'(0));
    chk("R10", "irq dropped", 64'(irq), 64'(0));
  endtask

  task automatic t_even();
    int de = data_err;
    @(posedge clk);
    stall_en = 1'b1;
    clear_log();
    kick(32'h1000_0800, 8, 2, 4, 0);
    wait_idle("R4");
    chk("R4", "burst count", 64'(bn - bn_base), 64'(4));
    for (int i = 0; i < 4; i++) chk_burst("R4", i, 32'h1000_0800 + 32'(16 * i), 4);
    chk("R12", "data order under stalls", 64'(data_err - de), 64'(0));
    @(posedge clk);
    stall_en = 1'b0;
    clear_sts(3'b111);
  endtask

  task automatic t_boundary_4k();
    int de = data_err;
    clear_log();
    kick(32'h2000_0FF0, 16, 1, 8, 0);
    repeat (30) @(negedge clk);
    chk("R1", "one burst before pause", 64'(bn - bn_base), 64'(1));
    chk_burst("R1", 0, 32'h2000_0FF0, 4);
    chk("R1", "busy while paused", 64'(busy), 64'(1));
    chk("R1", "boundary bit", 64'(sts), 64'(3'b010));
    chk("R1", "irq on boundary", 64'(irq), 64'(1));
    clear_sts(3'b010);
    chk("R10", "boundary cleared, others untouched", 64'(sts), 64'(0));
    @(negedge clk);
    cfg_sys_addr = 32'h3000_0000;
    addr_load = 1'b1;
    @(negedge clk);
    addr_load = 1'b0;
    wait_idle("R1");
    chk("R1", "bursts after reload", 64'(bn - bn_base), 64'(3));
    chk_burst("R1", 1, 32'h3000_0000, 8);
    chk_burst("R1", 2, 32'h3000_0020, 4);
    chk("R9", "done after reload", 64'(sts), 64'(3'b001));
    chk("R12", "data order across pause", 64'(data_err - de), 64'(0));
    clear_sts(3'b111);
  endtask

  task automatic t_boundary_sel();
    clear_log();
    kick(32'h2000_6FF8, 4, 1, 4, 3);
    wait_idle("R2");
    chk("R2", "4 KB edge ignored at 32 KB pages", 64'(bn - bn_base), 64'(1));
    chk_burst("R2", 0, 32'h2000_6FF8, 4);
    chk("R2", "no boundary bit", 64'(sts), 64'(3'b001));
    clear_sts(3'b111);
    clear_log();
    kick(32'h2000_7FF8, 4, 1, 4, 3);
    repeat (20) @(negedge clk);
    chk("R2", "pause at 32 KB edge", 64'(bn - bn_base), 64'(1));
    chk_burst("R2", 0, 32'h2000_7FF8, 2);
    chk("R2", "boundary bit at 32 KB", 64'(sts), 64'(3'b010));
    @(negedge clk);
    cfg_sys_addr = 32'h5000_0000;
    addr_load = 1'b1;
    @(negedge clk);
    addr_load = 1'b0;
    wait_idle("R2");
    chk_burst("R2", 1, 32'h5000_0000, 2);
    clear_sts(3'b111);
  endtask

  task automatic t_error();
    int de;
    clear_log();
    @(posedge clk);
    err_burst = 3;
    race_en   = 1'b1;
    kick(32'h4000_0000, 8, 3, 4, 0);
    wait_idle("R5");
    chk("R5", "bursts before abort", 64'(bn - bn_base), 64'(4));
    chk("R6", "error bit kept over same-cycle clear", 64'(sts), 64'(3'b100));
    chk("R10", "set wins over clear", 64'(sts[2]), 64'(1));
    chk("R6", "irq on error", 64'(irq), 64'(1));
    chk("R7", "failed block address", 64'(err_blk_addr), 64'(32'h4000_0020));
    chk("R5", "buffer refuses data", 64'(buf_in_ready), 64'(0));
    @(posedge clk);
    err_burst = -1;
    race_en   = 1'b0;
    kick(32'h4000_0000, 4, 1, 4, 0);
    repeat (20) @(negedge clk);
    chk("R5", "start ignored while locked", 64'(bn - bn_base), 64'(4));
    chk("R5", "still idle while locked", 64'(busy), 64'(0));
    chk("R6", "error bit still sticky", 64'(sts[2]), 64'(1));
    clear_sts(3'b100);
    chk("R6", "error bit cleared by W1C", 64'(sts), 64'(0));
    // data reset and restart
    @(posedge clk);
    prod_en = 1'b0;
    repeat (3) @(negedge clk);
    data_rst = 1'b1;
    @(negedge clk);
    data_rst = 1'b0;
    @(posedge clk);
    resync = 1'b1;
    @(posedge clk);
    resync = 1'b0;
    @(negedge clk);
    chk("R8", "buffer open after data reset", 64'(buf_in_ready), 64'(1));
    chk("R7", "failed address kept over data reset", 64'(err_blk_addr), 64'(32'h4000_0020));
    @(posedge clk);
    prod_en = 1'b1;
    de = data_err;
    clear_log();
    repeat (4) @(negedge clk);
    kick(32'h4100_0000, 4, 1, 4, 0);
    wait_idle("R8");
    chk("R8", "restart bursts", 64'(bn - bn_base), 64'(1));
    chk_burst("R8", 0, 32'h4100_0000, 4);
    chk("R8", "fresh data after flush", 64'(data_err - de), 64'(0));
    chk("R9", "done after restart", 64'(sts), 64'(3'b001));
  endtask

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    @(posedge clk);
    prod_en = 1'b1;
    repeat (20) @(negedge clk);
    t_uneven();
    t_even();
    t_boundary_4k();
    t_boundary_sel();
    t_error();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule